// File: doc/BRIEF.md
# Shorted-Line Charger Detection Sequencer

This block runs a timed sequence on the two USB data lines. It passes only when the far end shorts DP to DM, which is how a wall charger behaves. A standard host port fails the sequence, and so does a charging-capable host port. The sequence starts from a one-cycle start pulse. VBUS must then stay valid for a settle window. After that, a weak current source is applied to DP for a first phase. Both lines must read high at the end of that phase. In the second phase a current sink is added on DM, and both lines must then read low.

The analog front end is outside the block. It receives two enables, one for the DP source and one for the DM sink, and returns two synchronized comparator flags, one per line. The sequence ends in one of three ways: it completes, it fails a check, or it is cut short by an abort request or a VBUS loss. In every case the block raises `done_o` for a single cycle. The `pass_o` output carries the verdict and keeps it until the next accepted start.

Phase lengths are parameters in clock cycles. The defaults assume a 250 MHz clock: 10 ms settle, 100 ms for the first phase and 40 ms for the second.

Top module: `dcd_seq`

## Requirements
- R1: `start_i` is accepted only while the block is idle, and it begins the VBUS settle window. A start pulse that arrives while a sequence is running has no effect on that sequence's length or result.
- R2: The first phase begins only after `vbus_ok_i` has been high for SETTLE_CYC consecutive cycles. A low cycle during the window restarts the count from zero.
- R3: During the first phase, `dp_src_en_o` is high for exactly PH1_CYC cycles and `dm_sink_en_o` stays low.
- R4: If DP or DM reads low in the last cycle of the first phase, the sequence ends: `done_o` pulses and `pass_o` is 0. The second phase is not entered.
- R5: During the second phase, `dm_sink_en_o` and `dp_src_en_o` are both high for exactly PH2_CYC cycles.
- R6: At the end of the second phase, `done_o` pulses. `pass_o` is 1 only if both DP and DM read low in the last cycle. A line that reads high there gives 0.
- R7: `done_o` is high for one cycle only. Both enables are low in that cycle and whenever the block is idle.
- R8: `pass_o` keeps its value until the next accepted start, which clears it to 0.
- R9: `abort_i`, or `vbus_ok_i` going low during either phase, ends the sequence on the next edge. `done_o` pulses, `pass_o` is 0, and both enables go low. `abort_i` also ends the settle window the same way.
- R10: When an abort arrives in the last cycle of the second phase, the abort takes priority over the line check and `pass_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin detection |
| vbus_ok_i | input | 1 | VBUS valid flag |
| abort_i | input | 1 | Cancels a running sequence |
| dp_hi_i | input | 1 | DP comparator flag, 1 = line high |
| dm_hi_i | input | 1 | DM comparator flag, 1 = line high |
| dp_src_en_o | output | 1 | Enable for the weak DP current source |
| dm_sink_en_o | output | 1 | Enable for the DM current sink |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| pass_o | output | 1 | Verdict: 1 = shorted-line charger found |

## Verification
The end-of-sequence line check and an abort can fall in the same cycle, the last cycle of the second phase. The bench provokes this with a shorted-line load, which alone would pass, and raises `abort_i` exactly in that cycle. It then requires `done_o` at the normal completion time with `pass_o` at 0. A start pulse landing mid-sequence is also provoked, and the bench judges it by an unchanged completion time and verdict.

// File: rtl/dcd_seq.sv
module dcd_seq #(
  parameter int unsigned SETTLE_CYC = 2_500_000,
  parameter int unsigned PH1_CYC    = 25_000_000,
  parameter int unsigned PH2_CYC    = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic vbus_ok_i,
  input  logic abort_i,
  input  logic dp_hi_i,
  input  logic dm_hi_i,
  output logic dp_src_en_o,
  output logic dm_sink_en_o,
  output logic done_o,
  output logic pass_o
);
  localparam int unsigned M1   = (SETTLE_CYC > PH1_CYC) ? SETTLE_CYC : PH1_CYC;
  localparam int unsigned MAXC = (M1 > PH2_CYC) ? M1 : PH2_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_PH1, ST_PH2} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          at_end, kill;

  always_comb begin
    case (state)
      ST_SETTLE: lim = CW'(SETTLE_CYC - 1);
      ST_PH1:    lim = CW'(PH1_CYC - 1);
      default:   lim = CW'(PH2_CYC - 1);
    endcase
  end

  assign at_end       = (cnt == lim);
  assign kill         = abort_i || !vbus_ok_i;
  assign dp_src_en_o  = (state == ST_PH1) || (state == ST_PH2);
  assign dm_sink_en_o = (state == ST_PH2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state  <= ST_SETTLE;
          cnt    <= '0;
          pass_o <= 1'b0;
        end
        ST_SETTLE: begin
          if (abort_i) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (!vbus_ok_i) begin
            cnt <= '0;
          end else if (at_end) begin
            state <= ST_PH1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PH1: begin
          if (kill) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (at_end) begin
            cnt <= '0;
            if (dp_hi_i && dm_hi_i) begin
              state <= ST_PH2;
            end else begin
              state  <= ST_IDLE;
              done_o <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (kill) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
          end else if (at_end) begin
            state  <= ST_IDLE;
            done_o <= 1'b1;
            pass_o <= !dp_hi_i && !dm_hi_i;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module dcd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic vbus_ok_i,
  input logic abort_i,
  input logic dp_src_en_o,
  input logic dm_sink_en_o,
  input logic done_o,
  input logic pass_o
);
  p_sink_inside_ph2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_sink_en_o |-> dp_src_en_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_enables_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!dp_src_en_o && !dm_sink_en_o));
  p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_src_en_o && abort_i) |=> (done_o && !dp_src_en_o && !pass_o));
  p_vbus_loss_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_src_en_o && !vbus_ok_i) |=> (done_o && !dp_src_en_o && !pass_o));
  p_pass_rises_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> done_o);
  p_pass_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_o) |-> ($past(start_i) || done_o));
  p_sink_after_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_src_en_o) |-> !dm_sink_en_o);
endmodule

bind dcd_seq dcd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .vbus_ok_i(vbus_ok_i),
  .abort_i(abort_i), .dp_src_en_o(dp_src_en_o), .dm_sink_en_o(dm_sink_en_o),
  .done_o(done_o), .pass_o(pass_o)
);

// File: tb/dcd_seq_tb_top.sv
module dcd_seq_tb_top;
  localparam int S  = 4;
  localparam int P1 = 12;
  localparam int P2 = 6;
  localparam int FULL = 1 + S + P1 + P2;

  localparam int L_CHARGER = 0;
  localparam int L_STDHOST = 1;
  localparam int L_CHPSINK = 2;
  localparam int L_CHPSRC  = 3;
  localparam int L_STUCKDP = 4;
  localparam int L_OPEN    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, vbus_ok_i = 1'b1, abort_i = 1'b0;
  logic dp_hi_i, dm_hi_i;
  logic dp_src_en_o, dm_sink_en_o, done_o, pass_o;
  int   load = L_CHARGER;
  int   checks = 0, errors = 0;

  always #2 clk = ~clk;

  dcd_seq #(.SETTLE_CYC(S), .PH1_CYC(P1), .PH2_CYC(P2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vbus_ok_i(vbus_ok_i),
    .abort_i(abort_i), .dp_hi_i(dp_hi_i), .dm_hi_i(dm_hi_i),
    .dp_src_en_o(dp_src_en_o), .dm_sink_en_o(dm_sink_en_o),
    .done_o(done_o), .pass_o(pass_o));

  always_comb begin
    case (load)
      L_CHARGER: begin dp_hi_i = dp_src_en_o && !dm_sink_en_o; dm_hi_i = dp_hi_i; end
      L_STDHOST: begin dp_hi_i = dp_src_en_o; dm_hi_i = 1'b0; end
      L_CHPSINK: begin dp_hi_i = 1'b0; dm_hi_i = 1'b0; end
      L_CHPSRC:  begin dp_hi_i = dp_src_en_o; dm_hi_i = dp_src_en_o; end
      L_STUCKDP: begin dp_hi_i = dp_src_en_o; dm_hi_i = dp_src_en_o && !dm_sink_en_o; end
      default:   begin dp_hi_i = dp_src_en_o; dm_hi_i = 1'b0; end
    endcase
  end

  function automatic int nat_len(int ld);
    return (ld == L_CHARGER || ld == L_CHPSRC || ld == L_STUCKDP) ? FULL : 1 + S + P1;
  endfunction

  function automatic bit nat_pass(int ld);
    return ld == L_CHARGER;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 abort, 2 vbus drop, 3 start while busy; applied after sample k
  task automatic run(int ld, int kind, int kill_k);
    int k = 0, src = 0, snk = 0, elen, ep;
    load = ld;
    elen = nat_len(ld);
    ep   = nat_pass(ld);
    if ((kind == 1 || kind == 2) && kill_k < elen) begin
      elen = kill_k + 1;
      ep   = 0;
    end
    @(negedge clk); start_i = 1'b1;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      start_i = 1'b0;
      if (done_o || k > 200) break;
      src += dp_src_en_o;
      snk += dm_sink_en_o;
      if (dm_sink_en_o && !dp_src_en_o) chk("R5 sink without source", 1, 0);
      if (k == kill_k) begin
        if (kind == 1) abort_i = 1'b1;
        if (kind == 2) vbus_ok_i = 1'b0;
        if (kind == 3) start_i = 1'b1;
      end
    end
    abort_i = 1'b0; vbus_ok_i = 1'b1; start_i = 1'b0;
    chk("R4/R6/R9 done time", k, elen);
    chk("R6/R9/R10 pass", pass_o, ep);
    chk("R7 enables off at done", dp_src_en_o | dm_sink_en_o, 0);
    chk("R3/R5 source cycles", src, (elen > 1 + S) ? elen - 1 - S : 0);
    chk("R5 sink cycles", snk, (elen > 1 + S + P1) ? elen - 1 - S - P1 : 0);
    @(negedge clk);
    chk("R7 done one cycle", done_o, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R7 reset source off", dp_src_en_o, 0);
    chk("R7 reset sink off", dm_sink_en_o, 0);
    chk("R8 reset pass", pass_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(L_CHARGER, 0, 0);                 // R3 R5 R6 pass
    repeat (5) @(negedge clk);
    chk("R8 pass held", pass_o, 1);
    run(L_STDHOST, 0, 0);                 // R4 DM low
    run(L_CHPSINK, 0, 0);                 // R4 DP low
    run(L_OPEN, 0, 0);                    // R4
    run(L_CHPSRC, 0, 0);                  // R6 DM high
    run(L_STUCKDP, 0, 0);                 // R6 DP high
    run(L_CHARGER, 1, FULL - 1);          // R10 abort on final check cycle
    run(L_CHARGER, 1, 2);                 // R9 abort during settle
    run(L_CHARGER, 2, 1 + S + P1 + 2);    // R9 VBUS loss in phase 2
    run(L_CHARGER, 2, 1 + S + 3);         // R9 VBUS loss in phase 1
    run(L_CHARGER, 3, 8);                 // R1 start while busy ignored
    chk("R1 busy start no effect", pass_o, 1);

    // R2: VBUS low after samples 2..3 restarts settle; three extra cycles
    begin
      int k = 0;
      load = L_CHARGER;
      @(negedge clk); start_i = 1'b1;
      forever begin
        @(posedge clk); k++;
        @(negedge clk);
        start_i = 1'b0;
        if (done_o || k > 200) break;
        if (k == 2) vbus_ok_i = 1'b0;
        if (k == 4) vbus_ok_i = 1'b1;
      end
      vbus_ok_i = 1'b1;
      chk("R2 settle restart", k, FULL + 3);
      chk("R2 pass after restart", pass_o, 1);
    end

    // R8: pass cleared by a new start
    @(negedge clk); load = L_STDHOST; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R8 cleared on start", pass_o, 0);
    repeat (FULL + 2) @(negedge clk);

    for (int t = 0; t < 40; t++) begin
      int ld = $urandom % 6;
      int kind = $urandom % 4;
      int kk = 1 + ($urandom % (FULL + 2));
      if (kind == 2 && kk <= S + 1) kind = 0;
      run(ld, kind, kk);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule